// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins two buses through a pair of independent one-way paths: one from the A side to the B side, and one back from B to A. Each path carries a parameterizable number of bits (18 by default). A single storage value per bit can behave as a level-sensitive latch or as an edge-triggered register, so the same path can pass data straight through, freeze it, or sample it on its own clock, with a clock enable that can hold off sampling.

Each path has four controls: a latch-enable, a path clock, an active-low clock enable and an active-low output enable. The tri-state output is modelled as a data vector plus a drive-valid flag. An I/O ring or a bus wrapper turns that pair into a driven or released wire. The two paths share only the asynchronous reset input. Each path releases that reset in step with its own clock.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While a path's latch-enable is 1, its output data equals its input data in the same cycle, whatever its clock and clock enable are doing.
- R2: While latch-enable is 0 and the path clock does not toggle, the output data keeps its previous value when the input data changes.
- R3: While latch-enable is 0 and the active-low clock enable is 0, a rising edge of the path clock loads the input data, which appears at the output right after that edge.
- R4: While latch-enable is 0 and the clock enable is 1, rising clock edges leave the output data unchanged.
- R5: The drive-valid output is the inverse of the active-low output enable. Toggling the output enable never alters the stored data, and a value can be loaded while the output is released.
- R6: The B-to-A path behaves like the A-to-B path with its own four controls, and no control or data of one path affects the other path's outputs.
- R7: When latch-enable goes from 1 to 0, the output keeps the input value that was present just before the fall, even if the input changes afterwards.
- R8: While the reset input is 0, both paths' stored values are 0. After reset is released, each path leaves reset on the second rising edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both paths |
| ab_clk | input | 1 | A-to-B path clock |
| ab_clk_en_n | input | 1 | A-to-B active-low clock enable |
| ab_le | input | 1 | A-to-B latch-enable (1 = transparent) |
| ab_oe_n | input | 1 | A-to-B active-low output enable |
| a_in | input | WIDTH | Data arriving from the A side |
| b_out | output | WIDTH | Data presented to the B side |
| b_out_vld | output | 1 | B-side drive flag (1 = driving, 0 = released) |
| ba_clk | input | 1 | B-to-A path clock |
| ba_clk_en_n | input | 1 | B-to-A active-low clock enable |
| ba_le | input | 1 | B-to-A latch-enable (1 = transparent) |
| ba_oe_n | input | 1 | B-to-A active-low output enable |
| b_in | input | WIDTH | Data arriving from the B side |
| a_out | output | WIDTH | Data presented to the A side |
| a_out_vld | output | 1 | A-side drive flag (1 = driving, 0 = released) |

## Verification
The riskiest internal state is the one-bit age marker. It records whether the register or the latch copy was written last. If that marker is wrong, a path shows a stale value right after latch-enable falls, or right after the first clock capture that follows a fall, and it does so at once with no latency to hide it. A capture mistake shows at the output one clock edge after the load. A hold mistake shows as output movement under a stopped clock or with the clock enable held high. Cross-path coupling shows only when one path is exercised while the other is frozen, so the tests keep one path still while driving the other.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  // Number of synchronizer stages used to release reset into a path clock.
  localparam int unsigned RST_STAGES = 2;
endpackage

// File: rtl/xcvr_rst_sync.sv
`timescale 1ns/1ps
module xcvr_rst_sync
  import xcvr_pkg::*;
(
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [RST_STAGES-1:0] sync_q;
  logic [RST_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[RST_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[RST_STAGES-1];
endmodule

// File: rtl/xcvr_store.sv
`timescale 1ns/1ps
module xcvr_store #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le,
  input  logic             ce_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] reg_q;
  logic [WIDTH-1:0] reg_d;
  logic             lat_mark;
  logic             reg_mark;
  logic             reg_mark_d;
  logic             reg_newer;

  // Register next state: follow input while transparent, capture when enabled.
  // On capture the marker is set unequal to the latch copy (register newer).
  always_comb begin
    reg_d      = reg_q;
    reg_mark_d = reg_mark;
    if (le) begin
      reg_d = din;
    end else if (!ce_n) begin
      reg_d      = din;
      reg_mark_d = ~lat_mark;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q    <= '0;
      reg_mark <= 1'b0;
    end else begin
      reg_q    <= reg_d;
      reg_mark <= reg_mark_d;
    end
  end

  // Level-sensitive copy: tracks the input and equalizes the marker while open.
  always_latch begin
    if (!rst_n) begin
      lat_q    = '0;
      lat_mark = 1'b0;
    end else if (le) begin
      lat_q    = din;
      lat_mark = reg_mark;
    end
  end

  assign reg_newer = (reg_mark != lat_mark);
  assign q = le ? din : (reg_newer ? reg_q : lat_q);

  // R3: an enabled edge with latch closed shows the sampled data afterwards
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !ce_n) |=> (le || q == $past(din)));

  // R4: edges with clock enable high leave the visible value alone
  assert_ce_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && ce_n) |=> (le || $stable(q)));

  // R4: the register itself is not written when disabled and closed
  assert_reg_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && ce_n) |=> $stable(reg_q));

  // R8: held reset keeps the stored value cleared
  assert_reset_clear_R8: assert property (@(posedge clk)
    (!rst_n && !le) |-> (q == '0));
endmodule

// File: rtl/xcvr_drive.sv
`timescale 1ns/1ps
module xcvr_drive #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] pad_data,
  output logic             pad_vld
);
  assign pad_vld  = ~oe_n;
  assign pad_data = q;
endmodule

// File: rtl/bidir_latch_xcvr.sv
`timescale 1ns/1ps
module bidir_latch_xcvr #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             rst_n,
  input  logic             ab_clk,
  input  logic             ab_clk_en_n,
  input  logic             ab_le,
  input  logic             ab_oe_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_out_vld,
  input  logic             ba_clk,
  input  logic             ba_clk_en_n,
  input  logic             ba_le,
  input  logic             ba_oe_n,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_out_vld
);
  localparam int unsigned NPATH = 2;

  logic             p_clk  [NPATH];
  logic             p_ce_n [NPATH];
  logic             p_le   [NPATH];
  logic             p_oe_n [NPATH];
  logic [WIDTH-1:0] p_din  [NPATH];
  logic [WIDTH-1:0] p_q    [NPATH];
  logic [WIDTH-1:0] p_dout [NPATH];
  logic             p_vld  [NPATH];
  logic             p_rst_n[NPATH];

  // Path 0 runs A to B, path 1 runs B to A.
  assign p_clk[0]  = ab_clk;
  assign p_ce_n[0] = ab_clk_en_n;
  assign p_le[0]   = ab_le;
  assign p_oe_n[0] = ab_oe_n;
  assign p_din[0]  = a_in;
  assign p_clk[1]  = ba_clk;
  assign p_ce_n[1] = ba_clk_en_n;
  assign p_le[1]   = ba_le;
  assign p_oe_n[1] = ba_oe_n;
  assign p_din[1]  = b_in;

  for (genvar gp = 0; gp < NPATH; gp++) begin : g_path
    xcvr_rst_sync u_rst (
      .clk       (p_clk[gp]),
      .rst_n_in  (rst_n),
      .rst_n_out (p_rst_n[gp])
    );
    xcvr_store #(.WIDTH(WIDTH)) u_store (
      .clk   (p_clk[gp]),
      .rst_n (p_rst_n[gp]),
      .le    (p_le[gp]),
      .ce_n  (p_ce_n[gp]),
      .din   (p_din[gp]),
      .q     (p_q[gp])
    );
    xcvr_drive #(.WIDTH(WIDTH)) u_drive (
      .oe_n     (p_oe_n[gp]),
      .q        (p_q[gp]),
      .pad_data (p_dout[gp]),
      .pad_vld  (p_vld[gp])
    );
  end

  assign b_out     = p_dout[0];
  assign b_out_vld = p_vld[0];
  assign a_out     = p_dout[1];
  assign a_out_vld = p_vld[1];
endmodule

// File: tb/tb_bidir_latch_xcvr.sv
`timescale 1ns/1ps
module tb_bidir_latch_xcvr;
  localparam int W = 18;

  logic sys_clk = 1'b0;
  logic run_ab = 1'b1;
  logic run_ba = 1'b1;
  logic rst_n = 1'b0;
  logic ab_clk_en_n = 1'b1, ab_le = 1'b0, ab_oe_n = 1'b0;
  logic ba_clk_en_n = 1'b1, ba_le = 1'b0, ba_oe_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_out_vld, b_out_vld;
  logic ab_clk, ba_clk;
  int n_run = 0;
  int n_fail = 0;

  always #4 sys_clk = ~sys_clk;
  assign ab_clk = sys_clk & run_ab;
  assign ba_clk = sys_clk & run_ba;

  bidir_latch_xcvr #(.WIDTH(W)) dut (
    .rst_n(rst_n), .ab_clk(ab_clk), .ab_clk_en_n(ab_clk_en_n), .ab_le(ab_le),
    .ab_oe_n(ab_oe_n), .a_in(a_in), .b_out(b_out), .b_out_vld(b_out_vld),
    .ba_clk(ba_clk), .ba_clk_en_n(ba_clk_en_n), .ba_le(ba_le),
    .ba_oe_n(ba_oe_n), .b_in(b_in), .a_out(a_out), .a_out_vld(a_out_vld)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge sys_clk);
  endtask

  task automatic t_reset;
    cycles(3);
    check("R8 b_out in reset", b_out, '0);
    check("R8 a_out in reset", a_out, '0);
    rst_n = 1'b1;
    cycles(4);
    check("R8 b_out after release", b_out, '0);
  endtask

  task automatic t_transparent;
    ab_le = 1'b1; ab_clk_en_n = 1'b0; a_in = 18'h2A5C3;
    #1 check("R1 follow first", b_out, 18'h2A5C3);
    a_in = 18'h15A3C;
    #1 check("R1 follow second", b_out, 18'h15A3C);
    cycles(1);
    check("R1 follow across edge", b_out, 18'h15A3C);
    ab_clk_en_n = 1'b1; a_in = 18'h3FFFF;
    #1 check("R1 follow ce off", b_out, 18'h3FFFF);
    cycles(1);
  endtask

  task automatic t_le_fall;
    run_ab = 1'b0;
    a_in = 18'h0BEEF;
    #1 check("R1 follow clock stopped", b_out, 18'h0BEEF);
    ab_le = 1'b0;
    #1 a_in = 18'h31234;
    #1 check("R7 keep value at fall", b_out, 18'h0BEEF);
    a_in = 18'h00001;
    #20 check("R2 hold with clock steady", b_out, 18'h0BEEF);
    @(negedge sys_clk);
    run_ab = 1'b1;
  endtask

  task automatic t_capture;
    ab_clk_en_n = 1'b0; a_in = 18'h1C0DE;
    cycles(1);
    check("R3 first capture", b_out, 18'h1C0DE);
    a_in = 18'h2FACE;
    #1 check("R3 no change before edge", b_out, 18'h1C0DE);
    cycles(1);
    check("R3 second capture", b_out, 18'h2FACE);
  endtask

  task automatic t_ce_off;
    ab_clk_en_n = 1'b1; a_in = 18'h12345;
    cycles(3);
    check("R4 edges ignored", b_out, 18'h2FACE);
  endtask

  task automatic t_oe;
    ab_oe_n = 1'b1;
    #1 check("R5 released flag", {17'b0, b_out_vld}, 18'h0);
    check("R5 data kept while released", b_out, 18'h2FACE);
    ab_clk_en_n = 1'b0; a_in = 18'h0A0A5;
    cycles(1);
    ab_clk_en_n = 1'b1;
    ab_oe_n = 1'b0;
    #1 check("R5 drive flag", {17'b0, b_out_vld}, 18'h1);
    check("R5 load while released", b_out, 18'h0A0A5);
    cycles(1);
  endtask

  task automatic t_independent;
    ba_clk_en_n = 1'b0; b_in = 18'h3C3C3;
    cycles(1);
    ba_clk_en_n = 1'b1;
    check("R6 B-to-A capture", a_out, 18'h3C3C3);
    check("R6 A-to-B unaffected", b_out, 18'h0A0A5);
    ab_le = 1'b1; ab_clk_en_n = 1'b0; ab_oe_n = 1'b1; a_in = 18'h05555;
    cycles(2);
    check("R6 B-to-A untouched by A-to-B", a_out, 18'h3C3C3);
    check("R6 flag untouched", {17'b0, a_out_vld}, 18'h1);
    ab_le = 1'b0; ab_clk_en_n = 1'b1; ab_oe_n = 1'b0;
    cycles(1);
    ba_le = 1'b1; b_in = 18'h2AAAA;
    #1 check("R6 B-to-A transparent", a_out, 18'h2AAAA);
    check("R6 A-to-B holds", b_out, 18'h05555);
    ba_oe_n = 1'b1;
    #1 check("R6 B-to-A released", {17'b0, a_out_vld}, 18'h0);
    check("R6 A-to-B flag", {17'b0, b_out_vld}, 18'h1);
    cycles(1);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_le_fall();
    t_capture();
    t_ce_off();
    t_oe();
    t_independent();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule